// File: doc/BRIEF.md
# Banked pseudo dual-port memory

This block is a data array that presents two independent request ports, each able to read or write one word per cycle, while the storage inside is built from several single-ported banks. Each request is steered to a bank through an address crossbar, using a bank-select field taken from the address. A return crossbar sends each bank's read word back to the port that asked for it. Seen from outside, the result behaves like a flat memory of 2^ADDR_W words, as long as the caller honours the stall signal.

Two requests that select the same bank in the same cycle cannot both be served by a single-ported bank. The block detects this bank conflict, serves one request and raises a stall on the other port for that cycle. The caller must then present the stalled request again. The losing port is picked either by fixed priority, where port 0 always wins, or by an alternating pointer. The choice is a parameter. The position of the bank-select field is also a parameter (`SEL_LSB`), so that the bank mapping can be matched to the access strides that matter.

Top module: `bank_pdp_mem`

## Requirements
- R1: A write accepted on either port stores its data so that a later accepted read of the same address, from either port, returns it.
- R2: The target bank of a request is addr[SEL_LSB +: log2(NUM_BANKS)], and the remaining address bits select the word inside the bank. Any legal SEL_LSB gives the same flat-memory contents, and only which address pairs conflict changes.
- R3: An accepted read raises that port's rvalid exactly one cycle later, with the addressed word on its rdata. In every other cycle rvalid is low.
- R4: A bank conflict exists when both ports request and their bank fields are equal, whatever mix of reads and writes. Exactly one request is then served. The other port's stall is high in the same cycle, and its request has no effect: a stalled write changes no word, and a stalled read produces no rvalid.
- R5: With ARB_MODE = ARB_FIXED, port 0 is never stalled, and port 1 loses every conflict.
- R6: With ARB_MODE = ARB_ALT, port 0 wins the first conflict after reset, and the winner alternates from one conflict to the next.
- R7: Two requests to different banks in the same cycle are both served, including a write on one port with a read on the other.
- R8: During and after reset, until a read is accepted, both rvalid outputs are low. A stall is raised only on a port that is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| p0_req | input | 1 | Port 0 request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_stall | output | 1 | Port 0 request not taken this cycle |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_req | input | 1 | Port 1 request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_stall | output | 1 | Port 1 request not taken this cycle |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DATA_W | Port 1 read data |

## Verification
The bench attacks the same-bank write-versus-read case. If a design let a stalled write through, the bank would be corrupted, and a later read would return the new word instead of the old one. It runs a run of conflicts in the alternating mode from reset, where a pointer that never toggles, or starts on the wrong port, shows up as a stall on the wrong port. It drives a stride-4 read pattern through two bank mappings: the low-field mapping must stall port 1 on every cycle and the middle-field mapping never. A wrong field slice would break both counts and the flat-memory comparison. Read data is also checked for being routed back from the correct bank in the cycle after acceptance, not from the bank the port is using now.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the banked pseudo dual-port memory.
// Assumes exactly two external ports; the arbitration style is chosen by enum.
package bpm_pkg;
    localparam int NPORT = 2;

    typedef enum logic {
        ARB_FIXED = 1'b0,   // port 0 always wins a bank conflict
        ARB_ALT   = 1'b1    // winner alternates between successive conflicts
    } arb_mode_e;
endpackage

// File: rtl/bpm_bank.sv
`timescale 1ns/1ps
// One single-ported storage bank: one read or one write per cycle.
// Read data is registered (one-cycle latency) and held until the next read.
// Assumes the crossbar never presents more than one request per cycle.
module bpm_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Storage write and registered read of the addressed row.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end
        if (en && !we) begin
            rdata_q <= mem[row];
        end
    end

    assign rdata = rdata_q;

    // R1: a served write is found in the row it addressed on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (mem[$past(row)] == $past(wdata)));
endmodule

// File: rtl/bpm_arbiter.sv
`timescale 1ns/1ps
// Bank-conflict detector and arbiter for two ports.
// A conflict is two requests with equal bank fields; one request is granted.
// ARB_FIXED: port 0 wins. ARB_ALT: a pointer, reset to port 0, flips after
// every conflict so the loser of one conflict wins the next.
module bpm_arbiter
    import bpm_pkg::*;
#(
    parameter int        BSEL_W   = 2,
    parameter arb_mode_e ARB_MODE = ARB_FIXED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req0,
    input  logic              req1,
    input  logic [BSEL_W-1:0] bank0,
    input  logic [BSEL_W-1:0] bank1,
    output logic              grant0,
    output logic              grant1
);
    logic conflict;
    logic win1;      // port 1 takes the current conflict
    logic prio_q;    // alternating pointer: 1 means port 1 wins next conflict

    // Conflict detection and grant decision.
    always_comb begin
        conflict = req0 && req1 && (bank0 == bank1);
        win1     = (ARB_MODE == ARB_ALT) ? prio_q : 1'b0;
        grant0   = req0 && !(conflict && win1);
        grant1   = req1 && !(conflict && !win1);
    end

    // Alternating pointer update, flipped on each conflict in ARB_ALT mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= 1'b0;
        end else if (conflict && (ARB_MODE == ARB_ALT)) begin
            prio_q <= ~prio_q;
        end
    end

    // R4: a conflict is resolved with exactly one grant
    a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (grant0 != grant1));

    // R5: in fixed mode a port 0 request is always granted
    a_r5_port0_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((ARB_MODE == ARB_FIXED) && req0) |-> grant0);

    // R6: back-to-back conflicts in alternating mode change the winner
    a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        ((ARB_MODE == ARB_ALT) && conflict && $past(conflict))
            |-> (grant0 == $past(grant1)));

    // R7: requests to different banks are both granted
    a_r7_both_served: assert property (@(posedge clk) disable iff (!rst_n)
        (req0 && req1 && (bank0 != bank1)) |-> (grant0 && grant1));
endmodule

// File: rtl/bpm_rd_return.sv
`timescale 1ns/1ps
// Read-return path for one port: remembers which bank served the read and
// selects that bank's registered output one cycle later, with a valid flag.
// Assumes banks hold their read register until their next read.
module bpm_rd_return #(
    parameter int NUM_BANKS = 4,
    parameter int BSEL_W    = 2,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [BSEL_W-1:0] bank_idx,
    input  logic [DATA_W-1:0] bank_rdata [NUM_BANKS],
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    logic              rvalid_q;
    logic [BSEL_W-1:0] bank_q;

    // Track an accepted read and the bank that will answer it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            bank_q   <= '0;
        end else begin
            rvalid_q <= rd_fire;
            if (rd_fire) begin
                bank_q <= bank_idx;
            end
        end
    end

    // Data crossbar leg: pick the answering bank.
    always_comb begin
        rdata = bank_rdata[bank_q];
    end

    assign rvalid = rvalid_q;
endmodule

// File: rtl/bank_pdp_mem.sv
`timescale 1ns/1ps
// Banked pseudo dual-port memory. Two request ports share NUM_BANKS
// single-ported banks through an address crossbar; a bank field at SEL_LSB
// picks the bank. Same-bank requests conflict and one port is stalled.
// Assumes NUM_BANKS is a power of two and SEL_LSB + log2(NUM_BANKS) <= ADDR_W.
module bank_pdp_mem
    import bpm_pkg::*;
#(
    parameter int        ADDR_W    = 8,
    parameter int        DATA_W    = 16,
    parameter int        NUM_BANKS = 4,
    parameter int        SEL_LSB   = 0,
    parameter arb_mode_e ARB_MODE  = ARB_FIXED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_req,
    input  logic              p0_we,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic              p0_stall,
    output logic              p0_rvalid,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_req,
    input  logic              p1_we,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_stall,
    output logic              p1_rvalid,
    output logic [DATA_W-1:0] p1_rdata
);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BSEL_W;
    localparam int SEL_HI = SEL_LSB + BSEL_W;

    logic              req   [NPORT];
    logic              we    [NPORT];
    logic [ADDR_W-1:0] addr  [NPORT];
    logic [DATA_W-1:0] wdata [NPORT];
    logic [BSEL_W-1:0] bsel  [NPORT];
    logic [ROW_W-1:0]  row   [NPORT];
    logic              grant [NPORT];
    logic              rvld  [NPORT];
    logic [DATA_W-1:0] rdat  [NPORT];
    logic [DATA_W-1:0] bk_rdata [NUM_BANKS];

    assign req[0]   = p0_req;
    assign req[1]   = p1_req;
    assign we[0]    = p0_we;
    assign we[1]    = p1_we;
    assign addr[0]  = p0_addr;
    assign addr[1]  = p1_addr;
    assign wdata[0] = p0_wdata;
    assign wdata[1] = p1_wdata;

    // Address split per port: bank field out, remaining bits form the row.
    for (genvar p = 0; p < NPORT; p++) begin : g_split
        assign bsel[p] = addr[p][SEL_LSB +: BSEL_W];
        if (SEL_LSB == 0) begin : g_low
            assign row[p] = addr[p][ADDR_W-1:BSEL_W];
        end else if (SEL_HI == ADDR_W) begin : g_high
            assign row[p] = addr[p][SEL_LSB-1:0];
        end else begin : g_mid
            assign row[p] = {addr[p][ADDR_W-1:SEL_HI], addr[p][SEL_LSB-1:0]};
        end
    end

    bpm_arbiter #(
        .BSEL_W   (BSEL_W),
        .ARB_MODE (ARB_MODE)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req0   (req[0]),
        .req1   (req[1]),
        .bank0  (bsel[0]),
        .bank1  (bsel[1]),
        .grant0 (grant[0]),
        .grant1 (grant[1])
    );

    // Address crossbar and banks.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BSEL_W-1:0] BID = BSEL_W'(b);
        logic              bk_en;
        logic              bk_we;
        logic [ROW_W-1:0]  bk_row;
        logic [DATA_W-1:0] bk_wd;

        // Route the granted port that targets this bank, if any.
        always_comb begin
            bk_en  = 1'b0;
            bk_we  = 1'b0;
            bk_row = row[0];
            bk_wd  = wdata[0];
            if (grant[0] && (bsel[0] == BID)) begin
                bk_en  = 1'b1;
                bk_we  = we[0];
                bk_row = row[0];
                bk_wd  = wdata[0];
            end else if (grant[1] && (bsel[1] == BID)) begin
                bk_en  = 1'b1;
                bk_we  = we[1];
                bk_row = row[1];
                bk_wd  = wdata[1];
            end
        end

        bpm_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bk_en),
            .we    (bk_we),
            .row   (bk_row),
            .wdata (bk_wd),
            .rdata (bk_rdata[b])
        );

        // R2: the arbiter never sends two granted requests into one bank
        a_r2_bank_single: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant[0] && grant[1] && (bsel[0] == BID) && (bsel[1] == BID)));
    end

    // Data crossbar: one return leg per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_ret
        bpm_rd_return #(
            .NUM_BANKS (NUM_BANKS),
            .BSEL_W    (BSEL_W),
            .DATA_W    (DATA_W)
        ) u_ret (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_fire    (grant[p] && !we[p]),
            .bank_idx   (bsel[p]),
            .bank_rdata (bk_rdata),
            .rvalid     (rvld[p]),
            .rdata      (rdat[p])
        );
    end

    assign p0_stall  = req[0] && !grant[0];
    assign p1_stall  = req[1] && !grant[1];
    assign p0_rvalid = rvld[0];
    assign p1_rvalid = rvld[1];
    assign p0_rdata  = rdat[0];
    assign p1_rdata  = rdat[1];

    // R3: an accepted read on port 0 is answered next cycle
    a_r3_p0_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_stall && !p0_we) |=> p0_rvalid);
    // R3: no port 0 valid without an accepted read
    a_r3_p0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_req && !p0_stall && !p0_we) |=> !p0_rvalid);
    // R3: an accepted read on port 1 is answered next cycle
    a_r3_p1_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && !p1_stall && !p1_we) |=> p1_rvalid);
    // R3: no port 1 valid without an accepted read
    a_r3_p1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(p1_req && !p1_stall && !p1_we) |=> !p1_rvalid);
    // R8: a stall only appears on a requesting port
    a_r8_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_stall || p1_stall) |-> (p0_req && p1_req && !(p0_stall && p1_stall)));
endmodule

// File: tb/bank_pdp_mem_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives both DUT copies, checks stalls
// against a flat reference model and queues the expected read returns;
// the monitor pops and compares them one cycle later.
module bank_pdp_mem_tb;
    import bpm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        s0_req = 0, s0_we = 0, s1_req = 0, s1_we = 0;
    logic [7:0]  s0_addr = 0, s1_addr = 0;
    logic [15:0] s0_wd = 0, s1_wd = 0;

    logic        a0_stall, a0_rv, a1_stall, a1_rv;
    logic [15:0] a0_rd, a1_rd;
    logic        b0_stall, b0_rv, b1_stall, b1_rv;
    logic [15:0] b0_rd, b1_rd;

    // Copy A: low-order bank field, fixed priority.
    bank_pdp_mem #(.ADDR_W(8), .DATA_W(16), .NUM_BANKS(4), .SEL_LSB(0),
                   .ARB_MODE(ARB_FIXED)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .p0_req(s0_req), .p0_we(s0_we), .p0_addr(s0_addr), .p0_wdata(s0_wd),
        .p0_stall(a0_stall), .p0_rvalid(a0_rv), .p0_rdata(a0_rd),
        .p1_req(s1_req), .p1_we(s1_we), .p1_addr(s1_addr), .p1_wdata(s1_wd),
        .p1_stall(a1_stall), .p1_rvalid(a1_rv), .p1_rdata(a1_rd));

    // Copy B: middle bank field (bits 4:3), alternating priority.
    bank_pdp_mem #(.ADDR_W(8), .DATA_W(16), .NUM_BANKS(4), .SEL_LSB(3),
                   .ARB_MODE(ARB_ALT)) u_dut_alt (
        .clk(clk), .rst_n(rst_n),
        .p0_req(s0_req), .p0_we(s0_we), .p0_addr(s0_addr), .p0_wdata(s0_wd),
        .p0_stall(b0_stall), .p0_rvalid(b0_rv), .p0_rdata(b0_rd),
        .p1_req(s1_req), .p1_we(s1_we), .p1_addr(s1_addr), .p1_wdata(s1_wd),
        .p1_stall(b1_stall), .p1_rvalid(b1_rv), .p1_rdata(b1_rd));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] ref_a [256];
    logic [15:0] ref_b [256];
    bit          alt_prio = 0;
    int          obs_a = 0;
    int          obs_b = 0;

    bit [16:0] qa0[$], qa1[$], qb0[$], qb1[$];
    string     ta0[$], ta1[$], tb0[$], tb1[$];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int bank_of(input int a, input int lsb);
        return (a >> lsb) & 3;
    endfunction

    // One cycle of stimulus on both copies, with model update.
    task automatic step(input bit r0, input bit w0, input int a0, input int d0,
                        input bit r1, input bit w1, input int a1, input int d1,
                        input string tag);
        bit ca, cb, ga0, ga1, gb0, gb1;
        @(negedge clk);
        s0_req = r0; s0_we = w0; s0_addr = 8'(a0); s0_wd = 16'(d0);
        s1_req = r1; s1_we = w1; s1_addr = 8'(a1); s1_wd = 16'(d1);
        #1;
        ca  = r0 && r1 && (bank_of(a0, 0) == bank_of(a1, 0));
        ga0 = r0;
        ga1 = r1 && !ca;
        cb  = r0 && r1 && (bank_of(a0, 3) == bank_of(a1, 3));
        gb0 = r0 && !(cb && alt_prio);
        gb1 = r1 && !(cb && !alt_prio);
        if (cb) alt_prio = !alt_prio;
        chk(a0_stall == (r0 && !ga0), tag, "A p0_stall", a0_stall, r0 && !ga0);
        chk(a1_stall == (r1 && !ga1), tag, "A p1_stall", a1_stall, r1 && !ga1);
        chk(b0_stall == (r0 && !gb0), tag, "B p0_stall", b0_stall, r0 && !gb0);
        chk(b1_stall == (r1 && !gb1), tag, "B p1_stall", b1_stall, r1 && !gb1);
        if (a1_stall) obs_a++;
        if (b1_stall || b0_stall) obs_b++;
        qa0.push_back({ga0 && !w0, ref_a[a0[7:0]]}); ta0.push_back(tag);
        qa1.push_back({ga1 && !w1, ref_a[a1[7:0]]}); ta1.push_back(tag);
        qb0.push_back({gb0 && !w0, ref_b[a0[7:0]]}); tb0.push_back(tag);
        qb1.push_back({gb1 && !w1, ref_b[a1[7:0]]}); tb1.push_back(tag);
        if (ga0 && w0) ref_a[a0[7:0]] = 16'(d0);
        if (ga1 && w1) ref_a[a1[7:0]] = 16'(d1);
        if (gb0 && w0) ref_b[a0[7:0]] = 16'(d0);
        if (gb1 && w1) ref_b[a1[7:0]] = 16'(d1);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    endtask

    task automatic cmp_ret(inout bit [16:0] q[$], inout string t[$],
                           input logic rv, input logic [15:0] rd, input string nm);
        bit [16:0] e;
        string     tg;
        if (q.size() == 0) begin
            chk(rv == 1'b0, "R3", {nm, " rvalid idle"}, rv, 0);
        end else begin
            e  = q.pop_front();
            tg = t.pop_front();
            chk(rv == e[16], tg, {nm, " rvalid"}, rv, e[16]);
            if (e[16] && rv) chk(rd == e[15:0], tg, {nm, " rdata"}, rd, e[15:0]);
        end
    endtask

    // Monitor: compare read returns shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                cmp_ret(qa0, ta0, a0_rv, a0_rd, "A p0");
                cmp_ret(qa1, ta1, a1_rv, a1_rd, "A p1");
                cmp_ret(qb0, tb0, b0_rv, b0_rd, "B p0");
                cmp_ret(qb1, tb1, b1_rv, b1_rd, "B p1");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R8: outputs quiet in reset
        chk(!a0_rv && !a1_rv && !b0_rv && !b1_rv, "R8", "rvalid in reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!a0_rv && !a1_rv && !b0_rv && !b1_rv, "R8", "rvalid after reset", 1, 0);
        chk(!a0_stall && !a1_stall && !b0_stall && !b1_stall, "R8",
            "stall with no request", 1, 0);

        // R1: fill every word through port 0
        for (int i = 0; i < 256; i++) step(1, 1, i, (i * 37) ^ 16'h5a00, 0, 0, 0, 0, "R1");

        // R6: repeated same-bank conflict on copy B (bank field 4:3 = 0)
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 8'h20, 0, 1, 0, 8'h01, 0, "R6");
            chk(b1_stall == ((k % 2) == 0), "R6", "alternating p1 stall", b1_stall, (k % 2) == 0);
            chk(b0_stall == ((k % 2) == 1), "R6", "alternating p0 stall", b0_stall, (k % 2) == 1);
        end

        // R5: same-bank reads on copy A, port 1 must lose
        step(1, 0, 4, 0, 1, 0, 8, 0, "R5");
        chk(a1_stall == 1'b1 && a0_stall == 1'b0, "R5", "fixed p1 loses", a1_stall, 1);

        // R4: stalled write on copy A must not change word 8
        step(1, 0, 4, 0, 1, 1, 8, 16'hbeef, "R4");
        step(1, 0, 8, 0, 0, 0, 0, 0, "R4");
        idle();

        // R7: write and read to different banks, both served on copy A
        step(1, 1, 5, 16'h1234, 1, 0, 6, 0, "R7");
        chk(!a0_stall && !a1_stall, "R7", "no stall distinct banks", a1_stall, 0);
        step(1, 0, 5, 0, 1, 0, 6, 0, "R7");
        idle();

        // R2: stride-4 reads, p1 offset by 8: low field conflicts every cycle
        obs_a = 0;
        obs_b = 0;
        for (int i = 0; i < 32; i++) step(1, 0, (4 * i) & 255, 0, 1, 0, (4 * i + 8) & 255, 0, "R2");
        chk(obs_a == 32, "R2", "low-field conflict count", obs_a, 32);
        chk(obs_b == 0, "R2", "mid-field conflict count", obs_b, 0);

        // R4: random mixed traffic against the flat model
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom), 1'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                 1'($urandom), 1'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                 "R4");
        end
        idle();
        idle();
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule